// File: doc/BRIEF.md
# Whole-Period Reciprocal Measurement Cell

This cell measures an input signal over a window made of a programmable number of complete periods, where each period runs from one rising edge of the input to the next. Because the window always opens and closes on rising edges, it never includes a partial pulse. That whole-period locking is what gives reciprocal-counter precision, rather than the jitter of a fixed-gate count.

Two measurement kinds are selectable. In elapsed mode, the result is the number of system clocks that pass across the window. In high-time mode, the result is the number of clocks inside that same window during which the input was high. Clocks before the window opens and after it closes are not counted.

The cell runs continuously. It publishes a result and raises an event flag after every window. A pair of cells fed by the same input, one in each mode, supplies both the data for period or frequency and the data for duty cycle. The division that turns these counts into frequency or duty is left to the consumer.

Top module: `recip_period_cell`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `z_out` is 0, `evt` is 0 and `ovr` is 0.
- R2: With `mode` = 0 (elapsed), each published result equals the total number of clocks spanned by `n_periods` complete input periods.
- R3: With `mode` = 1 (high-time), each published result equals the number of clocks in which `a_in` was high within those same `n_periods` complete periods.
- R4: An `n_periods` value of 0 behaves exactly as a value of 1.
- R5: After `en` rises, the first window opens on the first rising edge of `a_in`. Clocks before that edge, including any time `a_in` was already high, are not counted.
- R6: The rising edge that closes one window opens the next one, so results are published exactly one window length apart and no clock is lost between windows.
- R7: `evt` rises when a result is published and falls on the clock after `ack` is sampled high. A pending `evt` never blocks a later result, which simply overwrites `z_out`.
- R8: `ovr` becomes 1 when a result is published while `evt` is still pending and `ack` is low. It returns to 0 on the clock after `ack` is sampled high.
- R9: While `en` is low, no result is published and `z_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low clears the window state |
| mode | input | 1 | 0 = count elapsed clocks, 1 = count high clocks |
| a_in | input | 1 | Measured input signal |
| n_periods | input | CNT_W | Number of whole periods per window (0 acts as 1) |
| ack | input | 1 | Acknowledge; clears the event flag and overrun |
| z_out | output | CNT_W | Most recently published result |
| evt | output | 1 | Result-ready event flag |
| ovr | output | 1 | A result arrived while the event flag was still pending |

## Verification
The bench builds the cell with its default 32-bit count width. At that width the period counter and the accumulator never wrap within the short windows used, so every expected value is an exact product of period count and pulse length. Period counts from 0 up to 5 bring within reach the single-period window, the zero-as-one rule, and multi-period windows whose boundaries fall on reused edges. Patterns as short as one clock high and one clock low exercise the rising edge that closes one window and opens the next in the same cycle.

// File: rtl/rpc_pkg.sv
// Package: shared types for the reciprocal measurement cell.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package rpc_pkg;
    // Kind of clock counted inside a measurement window.
    typedef enum logic {
        MEAS_ELAPSED = 1'b0,
        MEAS_HIGH    = 1'b1
    } meas_mode_e;
endpackage

// File: rtl/rpc_edge_detect.sv
// Registers the measured input once and flags a rising edge.
// Assumes a_in is already synchronous to clk.
module rpc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic a_in,
    output logic level,
    output logic rise
);
    logic a_q;
    logic a_prev;

    // Two-stage history of the input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= 1'b0;
            a_prev <= 1'b0;
        end else begin
            a_q    <= a_in;
            a_prev <= a_q;
        end
    end

    assign level = a_q;
    assign rise  = a_q & ~a_prev;
endmodule

// File: rtl/rpc_window_ctrl.sv
// Tracks whole periods of the input and marks window start and end.
// A window opens on a rising edge and closes on the rising edge that
// completes the requested number of periods. That same edge opens the
// next window. A period count of zero is handled as one.
module rpc_window_ctrl #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise,
    input  logic [CNT_W-1:0] n_periods,
    output logic             active,
    output logic             start,
    output logic             publish
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] per_cnt;
    logic [CNT_W-1:0] per_next;
    logic [CNT_W-1:0] goal;
    logic             last;

    assign goal     = (n_periods == '0) ? ONE : n_periods;
    assign per_next = per_cnt + ONE;
    assign last     = (per_next == goal);
    assign start    = en & rise & (~active | last);
    assign publish  = en & rise & active & last;

    // Window activity and completed-period counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            active  <= 1'b0;
            per_cnt <= '0;
        end else if (rise) begin
            active  <= 1'b1;
            per_cnt <= (!active || last) ? '0 : per_next;
        end
    end
endmodule

// File: rtl/rpc_accum.sv
// Counts clocks inside the current window. In elapsed mode every clock
// counts; in high-time mode only clocks with the input high count. The
// edge cycle that opens a window is the window's first clock.
module rpc_accum #(
    parameter int CNT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  rpc_pkg::meas_mode_e mode,
    input  logic                level,
    input  logic                active,
    input  logic                start,
    output logic [CNT_W-1:0]    acc
);
    logic [CNT_W-1:0] inc;

    assign inc = (mode == rpc_pkg::MEAS_ELAPSED) ? CNT_W'(1) : CNT_W'(level);

    // Accumulator: reload on window start, add while active.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc <= '0;
        end else if (start) begin
            acc <= CNT_W'(1);
        end else if (active) begin
            acc <= acc + inc;
        end
    end
endmodule

// File: rtl/rpc_result.sv
// Holds the published result, the event flag and the overrun status.
// A new result always overwrites the old one; acknowledge clears both
// flags unless a publish in the same cycle sets the event again.
module rpc_result #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             publish,
    input  logic             ack,
    input  logic [CNT_W-1:0] acc,
    output logic [CNT_W-1:0] z_out,
    output logic             evt,
    output logic             ovr
);
    // Result capture plus event and overrun bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_out <= '0;
            evt   <= 1'b0;
            ovr   <= 1'b0;
        end else if (publish) begin
            z_out <= acc;
            evt   <= 1'b1;
            if (evt && !ack) begin
                ovr <= 1'b1;
            end else if (ack) begin
                ovr <= 1'b0;
            end
        end else if (ack) begin
            evt <= 1'b0;
            ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/recip_period_cell.sv
// Top level of the whole-period measurement cell. It chains the edge
// detector, the window controller, the accumulator and the result
// holder. Input a_in must already be synchronous to clk.
module recip_period_cell #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode,
    input  logic             a_in,
    input  logic [CNT_W-1:0] n_periods,
    input  logic             ack,
    output logic [CNT_W-1:0] z_out,
    output logic             evt,
    output logic             ovr
);
    logic             level;
    logic             rise;
    logic             active;
    logic             start;
    logic             publish;
    logic [CNT_W-1:0] acc;
    rpc_pkg::meas_mode_e mode_e;

    assign mode_e = rpc_pkg::meas_mode_e'(mode);

    rpc_edge_detect edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .a_in  (a_in),
        .level (level),
        .rise  (rise)
    );

    rpc_window_ctrl #(.CNT_W(CNT_W)) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rise      (rise),
        .n_periods (n_periods),
        .active    (active),
        .start     (start),
        .publish   (publish)
    );

    rpc_accum #(.CNT_W(CNT_W)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .mode   (mode_e),
        .level  (level),
        .active (active),
        .start  (start),
        .acc    (acc)
    );

    rpc_result #(.CNT_W(CNT_W)) res_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .publish (publish),
        .ack     (ack),
        .acc     (acc),
        .z_out   (z_out),
        .evt     (evt),
        .ovr     (ovr)
    );
endmodule

// File: rtl/rpc_checker.sv
// Port-level properties of the measurement cell, attached by bind.
module rpc_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ack,
    input logic [CNT_W-1:0] z_out,
    input logic             evt,
    input logic             ovr
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (z_out == '0 && !evt && !ovr)); // R1

    AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt) |-> $past(en)); // R7

    AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(evt) && !$past(ack))); // R8

    AST_ACK_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ovr); // R8

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(z_out)); // R9
endmodule

bind recip_period_cell rpc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .ack   (ack),
    .z_out (z_out),
    .evt   (evt),
    .ovr   (ovr)
);

// File: tb/recip_period_cell_tb_top.sv
// Directed bench for the whole-period measurement cell.
module recip_period_cell_tb_top;
    localparam int CNT_W = 32;
    localparam int WDOG  = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             mode = 1'b0;
    logic             a_in = 1'b0;
    logic [CNT_W-1:0] n_periods = '0;
    logic             ack = 1'b0;
    logic [CNT_W-1:0] z_out;
    logic             evt;
    logic             ovr;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  hi_len = 1;
    int  lo_len = 1;
    logic gen_on = 1'b0;
    logic idle_lvl = 1'b0;

    recip_period_cell #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .a_in(a_in),
        .n_periods(n_periods), .ack(ack), .z_out(z_out), .evt(evt), .ovr(ovr)
    );

    always #2 clk = ~clk;

    // Cycle count and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Waveform source: low phase then high phase, driven on falling edges.
    initial begin
        forever begin
            if (!gen_on) begin
                a_in = idle_lvl;
                @(negedge clk);
            end else begin
                a_in = 1'b0;
                repeat (lo_len) @(negedge clk);
                a_in = 1'b1;
                repeat (hi_len) @(negedge clk);
            end
        end
    end

    task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_evt(input string req);
        int k;
        k = 0;
        while (evt !== 1'b1 && k < 4000) begin
            @(negedge clk);
            k++;
        end
        if (evt !== 1'b1) check(req, 0, 1);
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Quiet restart with new settings; the first result is clean.
    task automatic setup(input logic m, input int x, input int h, input int l);
        en = 1'b0;
        gen_on = 1'b0;
        idle_lvl = 1'b0;
        repeat (60) @(negedge clk);
        pulse_ack();
        mode = m;
        n_periods = CNT_W'(x);
        hi_len = h;
        lo_len = l;
        en = 1'b1;
        gen_on = 1'b1;
    endtask

    task automatic first_result(input string req, input logic [CNT_W-1:0] exp);
        wait_evt(req);
        check(req, z_out, exp);
        pulse_ack();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 z", z_out, 0);
        check("R1 evt", {31'b0, evt}, 0);
        check("R1 ovr", {31'b0, ovr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 z after release", z_out, 0);
    endtask

    task automatic t_elapsed();
        setup(1'b0, 4, 5, 7);
        first_result("R2 x4 p12", 48);
        setup(1'b0, 5, 1, 1);
        first_result("R2 x5 p2", 10);
        setup(1'b0, 1, 9, 3);
        first_result("R2 x1 p12", 12);
    endtask

    task automatic t_high();
        setup(1'b1, 3, 5, 7);
        first_result("R3 x3 h5", 15);
        setup(1'b1, 5, 1, 1);
        first_result("R3 x5 h1", 5);
        setup(1'b1, 2, 2, 11);
        first_result("R3 x2 h2", 4);
    endtask

    task automatic t_zero();
        setup(1'b0, 0, 4, 6);
        first_result("R4 zero elapsed", 10);
        setup(1'b1, 0, 4, 6);
        first_result("R4 zero high", 4);
    endtask

    task automatic t_first_edge();
        // Input already high at enable; that high time must not count.
        en = 1'b0;
        gen_on = 1'b0;
        idle_lvl = 1'b1;
        repeat (30) @(negedge clk);
        pulse_ack();
        mode = 1'b1;
        n_periods = 2;
        hi_len = 3;
        lo_len = 4;
        en = 1'b1;
        repeat (25) @(negedge clk);
        gen_on = 1'b1;
        first_result("R5 high at enable", 6);
        // Long low idle before pulses; idle must not count.
        en = 1'b0;
        gen_on = 1'b0;
        idle_lvl = 1'b0;
        repeat (20) @(negedge clk);
        pulse_ack();
        mode = 1'b0;
        en = 1'b1;
        repeat (50) @(negedge clk);
        gen_on = 1'b1;
        first_result("R5 low idle", 14);
    endtask

    task automatic t_spacing();
        int t0;
        setup(1'b0, 2, 3, 5);
        wait_evt("R6 first");
        t0 = cyc;
        pulse_ack();
        wait_evt("R6 second");
        check("R6 spacing", CNT_W'(cyc - t0), 16);
        check("R6 value", z_out, 16);
        pulse_ack();
    endtask

    task automatic t_evt_ovr();
        setup(1'b1, 2, 6, 14);
        wait_evt("R7 set");
        check("R7 evt set", {31'b0, evt}, 1);
        check("R8 no ovr yet", {31'b0, ovr}, 0);
        // Leave pending; next window must still publish and flag overrun.
        repeat (45) @(negedge clk);
        check("R8 ovr set", {31'b0, ovr}, 1);
        check("R7 evt pending", {31'b0, evt}, 1);
        // Change kind without ack; later windows overwrite the result.
        mode = 1'b0;
        repeat (130) @(negedge clk);
        check("R7 overwritten", z_out, 40);
        pulse_ack();
        check("R7 evt cleared", {31'b0, evt}, 0);
        check("R8 ovr cleared", {31'b0, ovr}, 0);
    endtask

    task automatic t_disable();
        logic [CNT_W-1:0] held;
        setup(1'b0, 1, 2, 3);
        first_result("R9 pre", 5);
        en = 1'b0;
        @(negedge clk);
        pulse_ack();
        held = z_out;
        repeat (100) @(negedge clk);
        check("R9 no evt", {31'b0, evt}, 0);
        check("R9 z held", z_out, held);
    endtask

    initial begin
        t_reset();
        t_elapsed();
        t_high();
        t_zero();
        t_first_edge();
        t_spacing();
        t_evt_ovr();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule